// File: doc/BRIEF.md
# Linked-List DMA Descriptor Sequencer

This block is the control engine of one DMA channel working through a chain of descriptors held in memory. Software pulses a go strobe with the address of the first descriptor. The sequencer reads that 40-byte descriptor as five 64-bit words over a simple read-master port. It loads the fields into the channel's control registers and starts a separate data mover with a start/done handshake. After the mover reports completion it follows the next-descriptor pointer. The chain stops when a descriptor carries the last-link flag.

The sequencer never fetches ahead. Each descriptor read begins only after the transfer of the previous descriptor has finished. A descriptor whose byte count is zero has no transfer, so the sequencer goes straight on to the link check. A failed descriptor read, a failed transfer or a misaligned head address ends the chain and leaves the error flag set. Successful completion sets a done flag and raises a one-cycle interrupt pulse.

Top module: `ll_dma_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, irq_o, rd_req_o and xfer_start_o are all low.
- R2: A go_i pulse while the channel is idle, with head_addr_i[2:0] equal to zero, makes busy_o high and rd_req_o high at head_addr_i in the next cycle. A go_i pulse while busy_o is high has no effect on the chain, the read addresses or the status.
- R3: A go_i pulse while idle with head_addr_i[2:0] nonzero issues no read and leaves busy_o low. It sets err_o and clears done_o in the next cycle.
- R4: A descriptor at address A is fetched as exactly five reads at A, A+8, A+16, A+24 and A+32, in that order. Only one read is outstanding at a time, and each read ends with one cycle of rd_ack_i.
- R5: The descriptor fields are driven on the outputs as follows: xfer_src_o is word 0, xfer_dst_o is word 1, xfer_src_attr_o is word 2 bits 63:32, xfer_dst_attr_o is word 2 bits 31:0, xfer_cnt_o is word 4 bits 63:32 and xfer_bcast_o is word 4 bits 31:0.
- R6: Once all five words are loaded, xfer_start_o pulses high for exactly one cycle. The transfer outputs stay stable until xfer_done_i or xfer_err_i.
- R7: From the xfer_start_o pulse until xfer_done_i, rd_req_o stays low, so no descriptor is prefetched.
- R8: Word 3 is the next-descriptor field, and its bit 0 is the last-link flag. If the flag is clear, the next descriptor is fetched from word 3 with bits 2:0 forced to zero. If the flag is set, the chain ends after the current transfer.
- R9: A descriptor with a byte count of zero produces no xfer_start_o pulse. The chain proceeds directly to the link decision.
- R10: When the last descriptor's transfer completes, busy_o falls, done_o rises and irq_o is high for exactly one cycle. An accepted go_i clears both done_o and err_o.
- R11: A read response with rd_err_i high together with rd_ack_i aborts the chain. The sequencer sets err_o, returns to idle and issues no further read or transfer start.
- R12: xfer_err_i during a transfer aborts the chain. The sequencer sets err_o, leaves done_o low, returns to idle and fetches no further descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Start strobe, one cycle |
| head_addr_i | input | ADDR_W | Address of the first descriptor |
| busy_o | output | 1 | Chain in progress |
| done_o | output | 1 | Chain completed, sticky until next go |
| err_o | output | 1 | Chain aborted or refused, sticky until next go |
| irq_o | output | 1 | One-cycle completion pulse |
| rd_req_o | output | 1 | Descriptor read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Descriptor read address |
| rd_ack_i | input | 1 | Read response valid |
| rd_data_i | input | 64 | Read response data |
| rd_err_i | input | 1 | Read response carries an error (valid with rd_ack_i) |
| xfer_start_o | output | 1 | Start pulse to the data mover |
| xfer_src_o | output | 64 | Source address |
| xfer_dst_o | output | 64 | Destination address |
| xfer_src_attr_o | output | 32 | Source attributes |
| xfer_dst_attr_o | output | 32 | Destination attributes |
| xfer_cnt_o | output | 32 | Byte count |
| xfer_bcast_o | output | 32 | Destination broadcast select |
| xfer_done_i | input | 1 | Data mover finished the transfer |
| xfer_err_i | input | 1 | Data mover failed the transfer |

## Verification
If the word counter slips, the read addresses leave the A..A+32 sequence, or the fields reach the wrong outputs at the next xfer_start_o. Either shows within one descriptor. If the state register lets a fetch overlap a transfer, rd_req_o rises while the mover is still busy, and the checker sees it in that same cycle. If the state machine takes the wrong branch on the last-link flag, the zero-count test or an abort, the counts of reads and starts differ from the expected counts for that chain. Done, error and interrupt also end in the wrong state when the channel goes idle. This happens a few cycles after the last mover response.

// File: rtl/ll_dma_pkg.sv
package ll_dma_pkg;
   localparam int WORD_W      = 64;
   localparam int WORD_BYTES  = WORD_W / 8;
   localparam int ALIGN_BITS  = $clog2(WORD_BYTES);
   localparam int DESC_WORDS  = 5;
   localparam int IDX_W       = $clog2(DESC_WORDS);
   localparam int HALF_W      = WORD_W / 2;

   // Word slots inside one descriptor; the sequencer decodes these.
   localparam int SLOT_SRC  = 0;
   localparam int SLOT_DST  = 1;
   localparam int SLOT_ATTR = 2;
   localparam int SLOT_LINK = 3;
   localparam int SLOT_CNT  = 4;

   typedef logic [WORD_W-1:0] word_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_LOAD,
      ST_START,
      ST_WAIT,
      ST_CHECK
   } chain_st_e;
endpackage

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
   import ll_dma_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              launch_i,
   input  logic [ADDR_W-1:0]                 base_i,
   output logic                              rd_req_o,
   output logic [ADDR_W-1:0]                 rd_addr_o,
   input  logic                              rd_ack_i,
   input  word_t                             rd_data_i,
   input  logic                              rd_err_i,
   output logic [DESC_WORDS-1:0][WORD_W-1:0] words_o,
   output logic                              fetched_o,
   output logic                              fault_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

   if (ADDR_W <= ALIGN_BITS || ADDR_W > WORD_W) begin : g_bad_addr_w
      $error("dma_desc_fetch: ADDR_W out of range");
   end

   logic              active_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] base_q;
   logic              good_beat;

   assign good_beat = active_q && rd_ack_i && !rd_err_i;
   assign fetched_o = good_beat && (idx_q == LAST_IDX);
   assign fault_o   = active_q && rd_ack_i && rd_err_i;
   assign rd_req_o  = active_q;
   assign rd_addr_o = base_q + (ADDR_W'(idx_q) << ALIGN_BITS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         base_q   <= '0;
      end else if (launch_i) begin
         active_q <= 1'b1;
         idx_q    <= '0;
         base_q   <= base_i;
      end else if (fault_o || fetched_o) begin
         active_q <= 1'b0;
      end else if (good_beat) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   for (genvar k = 0; k < DESC_WORDS; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words_o[k] <= '0;
         else if (good_beat && idx_q == IDX_W'(k))
            words_o[k] <= rd_data_i;
      end
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import ll_dma_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              load_i,
   input  logic [DESC_WORDS-1:0][WORD_W-1:0] words_i,
   output word_t                             src_o,
   output word_t                             dst_o,
   output logic [HALF_W-1:0]                 src_attr_o,
   output logic [HALF_W-1:0]                 dst_attr_o,
   output logic [HALF_W-1:0]                 cnt_o,
   output logic [HALF_W-1:0]                 bcast_o,
   output logic [ADDR_W-1:0]                 next_addr_o,
   output logic                              last_o,
   output logic                              cnt_zero_o
);
   word_t link_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_o      <= '0;
         dst_o      <= '0;
         src_attr_o <= '0;
         dst_attr_o <= '0;
         cnt_o      <= '0;
         bcast_o    <= '0;
         link_q     <= '0;
      end else if (load_i) begin
         src_o      <= words_i[SLOT_SRC];
         dst_o      <= words_i[SLOT_DST];
         src_attr_o <= words_i[SLOT_ATTR][WORD_W-1:HALF_W];
         dst_attr_o <= words_i[SLOT_ATTR][HALF_W-1:0];
         cnt_o      <= words_i[SLOT_CNT][WORD_W-1:HALF_W];
         bcast_o    <= words_i[SLOT_CNT][HALF_W-1:0];
         link_q     <= words_i[SLOT_LINK];
      end
   end

   assign last_o      = link_q[0];
   assign cnt_zero_o  = (cnt_o == '0);
   assign next_addr_o = {link_q[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
endmodule

// File: rtl/dma_chain_ctl.sv
module dma_chain_ctl
   import ll_dma_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [ADDR_W-1:0] head_addr_i,
   output logic              launch_o,
   output logic [ADDR_W-1:0] launch_addr_o,
   input  logic              fetched_i,
   input  logic              fault_i,
   output logic              load_o,
   input  logic              cnt_zero_i,
   input  logic              last_i,
   input  logic [ADDR_W-1:0] next_addr_i,
   output logic              xfer_start_o,
   input  logic              xfer_done_i,
   input  logic              xfer_err_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic              irq_o
);
   chain_st_e st_q, st_d;
   logic      head_bad;
   logic      finish;

   assign head_bad = (head_addr_i[ALIGN_BITS-1:0] != '0);
   assign finish   = (st_q == ST_CHECK) && last_i;

   always_comb begin
      st_d          = st_q;
      launch_o      = 1'b0;
      launch_addr_o = head_addr_i;
      load_o        = 1'b0;
      xfer_start_o  = 1'b0;
      unique case (st_q)
         ST_IDLE: if (go_i && !head_bad) begin
            launch_o = 1'b1;
            st_d     = ST_FETCH;
         end
         ST_FETCH: begin
            if (fault_i)        st_d = ST_IDLE;
            else if (fetched_i) st_d = ST_LOAD;
         end
         ST_LOAD: begin
            load_o = 1'b1;
            st_d   = ST_START;
         end
         ST_START: begin
            if (cnt_zero_i) st_d = ST_CHECK;
            else begin
               xfer_start_o = 1'b1;
               st_d         = ST_WAIT;
            end
         end
         ST_WAIT: begin
            if (xfer_err_i)       st_d = ST_IDLE;
            else if (xfer_done_i) st_d = ST_CHECK;
         end
         ST_CHECK: begin
            if (last_i) st_d = ST_IDLE;
            else begin
               launch_o      = 1'b1;
               launch_addr_o = next_addr_i;
               st_d          = ST_FETCH;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         done_o <= 1'b0;
         err_o  <= 1'b0;
         irq_o  <= 1'b0;
      end else begin
         st_q  <= st_d;
         irq_o <= finish;
         if (st_q == ST_IDLE && go_i) begin
            done_o <= 1'b0;
            err_o  <= head_bad;
         end else if ((st_q == ST_FETCH && fault_i) ||
                      (st_q == ST_WAIT && xfer_err_i)) begin
            err_o <= 1'b1;
         end else if (finish) begin
            done_o <= 1'b1;
         end
      end
   end

   assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/ll_dma_seq.sv
module ll_dma_seq
   import ll_dma_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [ADDR_W-1:0] head_addr_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic              irq_o,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_ack_i,
   input  logic [63:0]       rd_data_i,
   input  logic              rd_err_i,
   output logic              xfer_start_o,
   output logic [63:0]       xfer_src_o,
   output logic [63:0]       xfer_dst_o,
   output logic [31:0]       xfer_src_attr_o,
   output logic [31:0]       xfer_dst_attr_o,
   output logic [31:0]       xfer_cnt_o,
   output logic [31:0]       xfer_bcast_o,
   input  logic              xfer_done_i,
   input  logic              xfer_err_i
);
   if (WORD_W != 64) begin : g_bad_word
      $error("ll_dma_seq: port widths assume 64-bit descriptor words");
   end

   logic                              launch;
   logic [ADDR_W-1:0]                 launch_addr;
   logic [DESC_WORDS-1:0][WORD_W-1:0] words;
   logic                              fetched, fault, load;
   logic                              cnt_zero, last;
   logic [ADDR_W-1:0]                 next_addr;

   dma_desc_fetch #(.ADDR_W(ADDR_W)) u_fetch (
      .clk(clk), .rst_n(rst_n),
      .launch_i(launch), .base_i(launch_addr),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
      .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .rd_err_i(rd_err_i),
      .words_o(words), .fetched_o(fetched), .fault_o(fault)
   );

   dma_chan_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .load_i(load), .words_i(words),
      .src_o(xfer_src_o), .dst_o(xfer_dst_o),
      .src_attr_o(xfer_src_attr_o), .dst_attr_o(xfer_dst_attr_o),
      .cnt_o(xfer_cnt_o), .bcast_o(xfer_bcast_o),
      .next_addr_o(next_addr), .last_o(last), .cnt_zero_o(cnt_zero)
   );

   dma_chain_ctl #(.ADDR_W(ADDR_W)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .go_i(go_i), .head_addr_i(head_addr_i),
      .launch_o(launch), .launch_addr_o(launch_addr),
      .fetched_i(fetched), .fault_i(fault), .load_o(load),
      .cnt_zero_i(cnt_zero), .last_i(last), .next_addr_i(next_addr),
      .xfer_start_o(xfer_start_o), .xfer_done_i(xfer_done_i), .xfer_err_i(xfer_err_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .irq_o(irq_o)
   );
endmodule

// File: rtl/ll_dma_seq_chk.sv
module ll_dma_seq_chk #(
   parameter int ADDR_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              go_i,
   input logic [ADDR_W-1:0] head_addr_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o,
   input logic              irq_o,
   input logic              rd_req_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              rd_ack_i,
   input logic              rd_err_i,
   input logic              xfer_start_o,
   input logic [63:0]       xfer_src_o,
   input logic [63:0]       xfer_dst_o,
   input logic [31:0]       xfer_cnt_o,
   input logic              xfer_done_i,
   input logic              xfer_err_i
);
   logic open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      open_q <= 1'b0;
      else if (xfer_start_o)           open_q <= 1'b1;
      else if (xfer_done_i || xfer_err_i) open_q <= 1'b0;
   end

   p_idle_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !rd_req_o && !xfer_start_o);

   p_go_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      go_i && !busy_o && head_addr_i[2:0] == 3'b0 |=>
         busy_o && rd_req_o && rd_addr_o == $past(head_addr_i));

   p_misalign_r3: assert property (@(posedge clk) disable iff (!rst_n)
      go_i && !busy_o && head_addr_i[2:0] != 3'b0 |=> err_o && !busy_o && !rd_req_o);

   p_aligned_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> rd_addr_o[2:0] == 3'b0);

   p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start_o |=> !xfer_start_o);

   p_stable_params_r6: assert property (@(posedge clk) disable iff (!rst_n)
      open_q && $past(open_q) |-> $stable(xfer_src_o) && $stable(xfer_dst_o) && $stable(xfer_cnt_o));

   p_no_prefetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      open_q |-> !rd_req_o);

   p_zero_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start_o |-> xfer_cnt_o != 32'd0);

   p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   p_irq_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> done_o && !busy_o && !err_o);

   p_rd_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o && rd_ack_i && rd_err_i |=> !busy_o && err_o && !rd_req_o);

   p_xfer_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
      open_q && xfer_err_i |=> !busy_o && err_o && !done_o);
endmodule

bind ll_dma_seq ll_dma_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .go_i(go_i), .head_addr_i(head_addr_i),
   .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .irq_o(irq_o),
   .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_err_i(rd_err_i),
   .xfer_start_o(xfer_start_o), .xfer_src_o(xfer_src_o), .xfer_dst_o(xfer_dst_o),
   .xfer_cnt_o(xfer_cnt_o), .xfer_done_i(xfer_done_i), .xfer_err_i(xfer_err_i)
);

// File: tb/sim_ll_dma_seq.sv
`timescale 1ns/1ps
module sim_ll_dma_seq;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          go_i = 1'b0;
   logic [AW-1:0] head_addr_i = '0;
   logic          busy_o, done_o, err_o, irq_o;
   logic          rd_req_o;
   logic [AW-1:0] rd_addr_o;
   logic          rd_ack_i = 1'b0;
   logic [63:0]   rd_data_i = '0;
   logic          rd_err_i = 1'b0;
   logic          xfer_start_o;
   logic [63:0]   xfer_src_o, xfer_dst_o;
   logic [31:0]   xfer_src_attr_o, xfer_dst_attr_o, xfer_cnt_o, xfer_bcast_o;
   logic          xfer_done_i = 1'b0;
   logic          xfer_err_i = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ll_dma_seq #(.ADDR_W(AW)) u0 (.*);

   int n_checks = 0;
   int n_errors = 0;

   logic [63:0] mem [0:255];
   logic [63:0] rd_log [0:63];
   int          n_reads, n_starts, irq_cycles, viol;
   bit          rd_err_en;
   logic [63:0] rd_err_addr;
   int          xfer_err_nth;
   bit          open_tb;
   int          countdown;
   logic [63:0] rec_src, rec_dst;
   logic [31:0] rec_sattr, rec_dattr, rec_cnt, rec_bcast;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic put_desc(input logic [63:0] a, input logic [63:0] src, input logic [63:0] dst,
                           input logic [31:0] sattr, input logic [31:0] dattr,
                           input logic [63:0] link, input logic [31:0] cnt, input logic [31:0] bc);
      mem[a[10:3]]     = src;
      mem[a[10:3] + 1] = dst;
      mem[a[10:3] + 2] = {sattr, dattr};
      mem[a[10:3] + 3] = link;
      mem[a[10:3] + 4] = {cnt, bc};
   endtask

   task automatic clr();
      n_reads = 0; n_starts = 0; irq_cycles = 0; viol = 0;
      rd_err_en = 1'b0; xfer_err_nth = 0;
   endtask

   task automatic go_pulse(input logic [63:0] a);
      @(negedge clk);
      go_i = 1'b1; head_addr_i = a;
      @(negedge clk);
      go_i = 1'b0;
   endtask

   task automatic wait_idle();
      int t = 0;
      while (busy_o && t < 3000) begin
         @(negedge clk);
         t++;
      end
      if (busy_o) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: channel still busy");
      end
      repeat (3) @(negedge clk);
   endtask

   // memory read responder: one-cycle ack per request
   always @(negedge clk) begin
      if (rd_req_o && !rd_ack_i) begin
         rd_ack_i  <= 1'b1;
         rd_data_i <= mem[rd_addr_o[10:3]];
         rd_err_i  <= rd_err_en && (rd_addr_o == rd_err_addr);
         if (n_reads < 64) rd_log[n_reads] = rd_addr_o;
         n_reads++;
      end else begin
         rd_ack_i <= 1'b0;
         rd_err_i <= 1'b0;
      end
   end

   // data mover model and no-prefetch monitor
   always @(negedge clk) begin
      xfer_done_i <= 1'b0;
      xfer_err_i  <= 1'b0;
      if (irq_o) irq_cycles++;
      if (open_tb && rd_req_o) viol++;
      if (xfer_start_o) begin
         n_starts++;
         rec_src = xfer_src_o; rec_dst = xfer_dst_o;
         rec_sattr = xfer_src_attr_o; rec_dattr = xfer_dst_attr_o;
         rec_cnt = xfer_cnt_o; rec_bcast = xfer_bcast_o;
         open_tb = 1'b1;
         countdown = 4;
      end else if (open_tb) begin
         countdown--;
         if (countdown == 0) begin
            if (n_starts == xfer_err_nth) xfer_err_i <= 1'b1;
            else                          xfer_done_i <= 1'b1;
            open_tb = 1'b0;
         end
      end
   end

   task automatic t_reset();
      chk("R1", "busy", busy_o, 0);
      chk("R1", "done", done_o, 0);
      chk("R1", "err", err_o, 0);
      chk("R1", "irq", irq_o, 0);
      chk("R1", "rd_req", rd_req_o, 0);
      chk("R1", "xfer_start", xfer_start_o, 0);
   endtask

   task automatic t_single();
      clr();
      put_desc(64'h100, 64'h1111_2222_3333_4440, 64'h5555_6666_7777_8880,
               32'hA1A1_0001, 32'hB2B2_0002, 64'h1, 32'h40, 32'h5);
      @(negedge clk);
      go_i = 1'b1; head_addr_i = 64'h100;
      @(negedge clk);
      go_i = 1'b0;
      chk("R2", "busy after go", busy_o, 1);
      chk("R2", "first read addr", rd_addr_o, 64'h100);
      wait_idle();
      chk("R4", "read count", n_reads, 5);
      for (int i = 0; i < 5; i++)
         chk("R4", "read address", rd_log[i], 64'h100 + 8*i);
      chk("R6", "start count", n_starts, 1);
      chk("R5", "src", rec_src, 64'h1111_2222_3333_4440);
      chk("R5", "dst", rec_dst, 64'h5555_6666_7777_8880);
      chk("R5", "src attr", rec_sattr, 32'hA1A1_0001);
      chk("R5", "dst attr", rec_dattr, 32'hB2B2_0002);
      chk("R5", "count", rec_cnt, 32'h40);
      chk("R5", "bcast", rec_bcast, 32'h5);
      chk("R10", "done", done_o, 1);
      chk("R10", "irq cycles", irq_cycles, 1);
      chk("R10", "err", err_o, 0);
   endtask

   task automatic build_chain3();
      put_desc(64'h200, 64'hA0, 64'hB0, 32'h1, 32'h2, 64'h280, 32'h10, 32'h0);
      put_desc(64'h280, 64'hA1, 64'hB1, 32'h3, 32'h4, 64'h306, 32'h20, 32'h0);
      put_desc(64'h300, 64'hA2, 64'hB2, 32'h5, 32'h6, 64'h1, 32'h30, 32'h7);
   endtask

   task automatic t_chain();
      clr();
      build_chain3();
      go_pulse(64'h200);
      wait_idle();
      chk("R8", "start count", n_starts, 3);
      chk("R8", "read count", n_reads, 15);
      chk("R8", "masked next fetch", rd_log[10], 64'h300);
      chk("R7", "prefetch violations", viol, 0);
      chk("R5", "last src", rec_src, 64'hA2);
      chk("R10", "irq cycles", irq_cycles, 1);
      chk("R10", "done", done_o, 1);
   endtask

   task automatic t_zero();
      clr();
      put_desc(64'h400, 64'hC0, 64'hD0, 32'h0, 32'h0, 64'h440, 32'h8, 32'h0);
      put_desc(64'h440, 64'hC1, 64'hD1, 32'h0, 32'h0, 64'h480, 32'h0, 32'h0);
      put_desc(64'h480, 64'hC2, 64'hD2, 32'h0, 32'h0, 64'h1, 32'h18, 32'h0);
      go_pulse(64'h400);
      wait_idle();
      chk("R9", "starts with zero-count middle", n_starts, 2);
      chk("R9", "reads", n_reads, 15);
      chk("R9", "last src", rec_src, 64'hC2);
      chk("R9", "done", done_o, 1);
   endtask

   task automatic t_misalign();
      clr();
      go_pulse(64'h504);
      repeat (5) @(negedge clk);
      chk("R3", "err", err_o, 1);
      chk("R3", "done cleared", done_o, 0);
      chk("R3", "busy", busy_o, 0);
      chk("R3", "reads", n_reads, 0);
   endtask

   task automatic t_rd_err();
      clr();
      build_chain3();
      rd_err_en = 1'b1; rd_err_addr = 64'h288;
      go_pulse(64'h200);
      wait_idle();
      repeat (20) @(negedge clk);
      chk("R11", "err", err_o, 1);
      chk("R11", "done", done_o, 0);
      chk("R11", "starts", n_starts, 1);
      chk("R11", "reads", n_reads, 7);
      chk("R11", "busy", busy_o, 0);
   endtask

   task automatic t_xfer_err();
      clr();
      build_chain3();
      xfer_err_nth = 1;
      go_pulse(64'h200);
      wait_idle();
      repeat (20) @(negedge clk);
      chk("R12", "err", err_o, 1);
      chk("R12", "done", done_o, 0);
      chk("R12", "reads", n_reads, 5);
      chk("R12", "starts", n_starts, 1);
      chk("R12", "irq cycles", irq_cycles, 0);
   endtask

   task automatic t_go_busy();
      clr();
      build_chain3();
      go_pulse(64'h200);
      repeat (12) @(negedge clk);
      go_i = 1'b1; head_addr_i = 64'h504;
      @(negedge clk);
      go_i = 1'b1; head_addr_i = 64'h100;
      @(negedge clk);
      go_i = 1'b0;
      wait_idle();
      chk("R2", "err untouched by busy go", err_o, 0);
      chk("R2", "done", done_o, 1);
      chk("R2", "reads", n_reads, 15);
      chk("R2", "starts", n_starts, 3);
      chk("R2", "first read", rd_log[0], 64'h200);
   endtask

   task automatic t_recover();
      clr();
      go_pulse(64'h504);
      repeat (3) @(negedge clk);
      go_pulse(64'h100);
      wait_idle();
      chk("R10", "err cleared by go", err_o, 0);
      chk("R10", "done", done_o, 1);
      chk("R10", "starts", n_starts, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++; n_errors++;
      $display("FAIL watchdog: run did not end");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      open_tb = 1'b0; countdown = 0;
      rd_err_addr = '0;
      clr();
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_single();
      t_chain();
      t_zero();
      t_misalign();
      t_rd_err();
      t_xfer_err();
      t_go_busy();
      t_recover();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule